// File: doc/BRIEF.md
# Memory-Mapped SPI Word Master

This block is a single-lane SPI master that sits behind a small synchronous register port of 16-bit registers. Software picks the word size, the SCK polarity and phase, the SCK rate and two interrupt enables in a control register. It then writes a word to the data register. That write shifts the word out on MOSI, MSB first, while the same number of bits is shifted in from MISO. Once the exchange completes, the received word waits in a one-word receive buffer until software reads it. To receive without sending anything useful, software writes a dummy zero. Chip selects come from general-purpose outputs elsewhere, so this block does not drive them.

The register port is not a stream. Each read or write completes in the cycle it is strobed, and there is no back-pressure. Software must watch the busy flag, or the transmit-ready interrupt, before it writes the next word. A data write that arrives while a word is in flight is dropped. SCK is derived from the system clock by a 7-bit divider N: each SCK half period lasts N+1 system clocks, which gives a total ratio of 2×(N+1), from 4 to 256. Clearing the enable bit aborts an exchange at once, which gives software a recovery path after a timeout.

Top module: `spi_word_master`

## Requirements
- R1: After reset the control register reads 0x0000, the status register reads 0x0000, SCK is low and the interrupt is low.
- R2: The control register sits at offset 0x02. Its fields are: bit 0 enable, bit 2 word size (1 = 16-bit, 0 = 8-bit), bit 5 receive interrupt enable, bit 6 transmit interrupt enable, bit 7 polarity (CPOL), bit 8 phase (CPHA), bits 15:9 divider N. Bits 1, 3 and 4 read back as zero, so writing 0xFFFF reads back 0xFFE5.
- R3: A write to the data register (offset 0x00) while the block is enabled and idle starts one exchange. Status bit 0 (busy, at offset 0x04) is set from the next cycle and stays set for exactly 2×W×(N+1) system clocks, where W is 8 or 16.
- R4: A divider value of N = 0 behaves as N = 1, so the shortest SCK period is four system clocks.
- R5: The exchange is full duplex and MSB first. SCK idles at the CPOL level. With CPHA = 0, MISO is sampled on leading edges and MOSI changes on trailing edges, and the first bit is presented at the start. With CPHA = 1, MOSI changes on leading edges and MISO is sampled on trailing edges. Mode m puts m[1] on bit 7 and m[0] on bit 8.
- R6: When no exchange is running, SCK sits at the current CPOL level, and MOSI holds the last bit sent, which is bit 0 of the word.
- R7: When an exchange completes, status bit 1 (receive full) is set and the word goes into the receive buffer. In 8-bit mode the upper byte of that word is zero. A read of the data register returns the word and clears receive full.
- R8: A data write is ignored when the block is disabled or already busy. It starts nothing and does not change the word in flight or its length.
- R9: Clearing the enable bit during an exchange drops busy on the following cycle, returns SCK to the CPOL level and leaves receive full clear.
- R10: The interrupt output is high exactly when the block is enabled and either receive full is set with the receive enable on, or busy is clear with the transmit enable on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe; a data read clears receive full |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for the addressed register |
| irq | output | 1 | Interrupt request |
| sck | output | 1 | SPI serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The cases that are hardest to reach from the ports are the ones timed against an exchange already in flight: a second data write that must be dropped, and a disable that must cut the word short. The stimulus reaches both by counting system clocks inside the busy-polling loop and injecting the write at a chosen count. It then checks that the busy time still equals the formula and that the slave model captured only the first word. A separate concern is phase 1, where the final sample edge coincides with completion. A bus-slave model in the bench drives MISO and captures MOSI on the edges the selected mode calls for, and a vector table covers all four modes, both word sizes and both divider extremes.

// File: rtl/spi_wm_pkg.sv
package spi_wm_pkg;
  localparam int REG_W    = 16;
  localparam int OFS_DATA = 0;
  localparam int OFS_CTRL = 2;
  localparam int OFS_STAT = 4;

  // control field positions
  localparam int B_EN     = 0;
  localparam int B_WIDE   = 2;
  localparam int B_RXIE   = 5;
  localparam int B_TXIE   = 6;
  localparam int B_CPOL   = 7;
  localparam int B_CPHA   = 8;
  localparam int B_DIV_LO = 9;
  localparam int DIV_W    = REG_W - B_DIV_LO;

  // status field positions
  localparam int S_BUSY   = 0;
  localparam int S_RXFULL = 1;

  localparam logic [REG_W-1:0] CTRL_MASK =
      (REG_W'(1) << B_EN)   | (REG_W'(1) << B_WIDE) |
      (REG_W'(1) << B_RXIE) | (REG_W'(1) << B_TXIE) |
      (REG_W'(1) << B_CPOL) | (REG_W'(1) << B_CPHA) |
      (REG_W'((1 << DIV_W) - 1) << B_DIV_LO);
endpackage

// File: rtl/spi_wm_regs.sv
module spi_wm_regs
  import spi_wm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic              rd,
  input  logic [REG_W-1:0]  wdata,
  input  logic              busy,
  input  logic              done,
  input  logic [REG_W-1:0]  rx_word,
  output logic [REG_W-1:0]  rdata,
  output logic              start,
  output logic              en,
  output logic              wide,
  output logic              cpol,
  output logic              cpha,
  output logic [DIV_W-1:0]  div,
  output logic              irq
);
  logic [REG_W-1:0] ctrl_q;
  logic [REG_W-1:0] rx_buf_q;
  logic             rx_full_q;
  logic             hit_data, hit_ctrl, hit_stat;

  assign hit_data = (addr == ADDR_W'(OFS_DATA));
  assign hit_ctrl = (addr == ADDR_W'(OFS_CTRL));
  assign hit_stat = (addr == ADDR_W'(OFS_STAT));

  assign en   = ctrl_q[B_EN];
  assign wide = ctrl_q[B_WIDE];
  assign cpol = ctrl_q[B_CPOL];
  assign cpha = ctrl_q[B_CPHA];
  assign div  = ctrl_q[REG_W-1:B_DIV_LO];

  assign start = wr && hit_data && en && !busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rx_buf_q  <= '0;
      rx_full_q <= 1'b0;
    end else begin
      if (wr && hit_ctrl) ctrl_q <= wdata & CTRL_MASK;
      if (done) begin
        rx_buf_q  <= rx_word;
        rx_full_q <= 1'b1;
      end else if (rd && hit_data) begin
        rx_full_q <= 1'b0;
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (hit_data)      rdata = rx_buf_q;
    else if (hit_ctrl) rdata = ctrl_q;
    else if (hit_stat) begin
      rdata[S_BUSY]   = busy;
      rdata[S_RXFULL] = rx_full_q;
    end
  end

  assign irq = en && ((rx_full_q && ctrl_q[B_RXIE]) || (!busy && ctrl_q[B_TXIE]));

  // R7: a completed exchange leaves the receive buffer marked full
  a_r7_done_full: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && $past(en)) |-> rx_full_q);
endmodule

// File: rtl/spi_wm_clkgen.sv
module spi_wm_clkgen #(
  parameter int DIV_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [DIV_W-1:0] div_q;
  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] limit;

  // zero is clamped to one so a half period is never shorter than two clocks
  assign limit = (div_q == '0) ? DIV_W'(1) : div_q;
  assign tick  = run && (cnt_q == limit);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_q <= '0;
      cnt_q <= '0;
    end else if (!run) begin
      div_q <= div;
      cnt_q <= '0;
    end else if (tick) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  // R4: edges are always at least two system clocks apart
  a_r4_tick_gap: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick);
endmodule

// File: rtl/spi_wm_shifter.sv
module spi_wm_shifter #(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic              start,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              wide_in,
  input  logic              cpol_in,
  input  logic              cpha_in,
  input  logic              tick,
  input  logic              miso,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_word,
  output logic              sck,
  output logic              mosi
);
  localparam int HALF   = DATA_W / 2;
  localparam int EDGE_W = $clog2(2 * DATA_W);

  logic              busy_q, sck_q, mosi_q, wide_q, cpha_q;
  logic [DATA_W-1:0] txsh_q, rxsh_q, rx_next, aligned;
  logic [EDGE_W-1:0] edge_cnt, last_edge;
  logic              is_last, sample_now;

  assign last_edge  = wide_q ? EDGE_W'(2 * DATA_W - 1) : EDGE_W'(2 * HALF - 1);
  assign is_last    = (edge_cnt == last_edge);
  assign sample_now = (edge_cnt[0] == cpha_q);
  assign rx_next    = sample_now ? {rxsh_q[DATA_W-2:0], miso} : rxsh_q;
  assign aligned    = wide_in ? tx_word : (tx_word << HALF);

  assign done    = busy_q && en && tick && is_last;
  assign rx_word = wide_q ? rx_next : {{(DATA_W-HALF){1'b0}}, rx_next[HALF-1:0]};
  assign busy    = busy_q;
  assign sck     = sck_q;
  assign mosi    = mosi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sck_q    <= 1'b0;
      mosi_q   <= 1'b0;
      wide_q   <= 1'b0;
      cpha_q   <= 1'b0;
      txsh_q   <= '0;
      rxsh_q   <= '0;
      edge_cnt <= '0;
    end else if (!en) begin
      busy_q <= 1'b0;
      sck_q  <= cpol_in;
    end else if (!busy_q) begin
      sck_q <= cpol_in;
      if (start) begin
        busy_q   <= 1'b1;
        wide_q   <= wide_in;
        cpha_q   <= cpha_in;
        edge_cnt <= '0;
        rxsh_q   <= '0;
        if (cpha_in) begin
          txsh_q <= aligned;
        end else begin
          mosi_q <= aligned[DATA_W-1];
          txsh_q <= aligned << 1;
        end
      end
    end else if (tick) begin
      sck_q    <= ~sck_q;
      edge_cnt <= edge_cnt + 1'b1;
      rxsh_q   <= rx_next;
      if (!sample_now && !is_last) begin
        mosi_q <= txsh_q[DATA_W-1];
        txsh_q <= txsh_q << 1;
      end
      if (is_last) busy_q <= 1'b0;
    end
  end

  // R3: an accepted start makes the engine busy on the next cycle
  a_r3_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (start && en && !busy_q) |=> busy_q);
  // R6: outside an exchange SCK follows the polarity setting
  a_r6_idle_sck: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(busy_q) |-> (sck_q == $past(cpol_in)));
  // R9: disabling stops the engine and parks SCK
  a_r9_abort_stop: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !en) |=> (!busy_q && sck_q == $past(cpol_in)));
  // R5: the edge counter never runs past the last edge of the word
  a_r5_edge_bound: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (edge_cnt <= last_edge));
endmodule

// File: rtl/spi_word_master.sv
module spi_word_master
  import spi_wm_pkg::*;
#(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  output logic              irq,
  output logic              sck,
  output logic              mosi,
  input  logic              miso
);
  logic             busy, done, start, en, wide, cpol, cpha, tick;
  logic [DIV_W-1:0] div;
  logic [REG_W-1:0] rx_word;

  spi_wm_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(reg_addr), .wr(reg_wr), .rd(reg_rd),
    .wdata(reg_wdata), .busy(busy), .done(done), .rx_word(rx_word),
    .rdata(reg_rdata), .start(start), .en(en), .wide(wide), .cpol(cpol),
    .cpha(cpha), .div(div), .irq(irq)
  );

  spi_wm_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst_n(rst_n), .run(busy), .div(div), .tick(tick)
  );

  spi_wm_shifter #(.DATA_W(REG_W)) u_shifter (
    .clk(clk), .rst_n(rst_n), .en(en), .start(start), .tx_word(reg_wdata),
    .wide_in(wide), .cpol_in(cpol), .cpha_in(cpha), .tick(tick), .miso(miso),
    .busy(busy), .done(done), .rx_word(rx_word), .sck(sck), .mosi(mosi)
  );
endmodule

// File: tb/test_spi_word_master.sv
`timescale 1ns/1ps
module test_spi_word_master;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq, sck, mosi;
  logic        miso = 1'b0;

  int checks = 0;
  int errors = 0;

  // slave model state
  logic        s_active = 1'b0;
  logic        s_cpol = 1'b0;
  logic        s_cpha = 1'b0;
  logic [15:0] s_word = '0;
  logic [15:0] s_cap = '0;
  int          s_idx = 0;

  always #2 clk = ~clk;

  spi_word_master i_spi_word_master (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq), .sck(sck), .mosi(mosi), .miso(miso)
  );

  always @(sck) begin
    if (s_active) begin
      logic lead;
      logic smp;
      lead = (sck != s_cpol);
      smp  = s_cpha ? !lead : lead;
      if (smp) begin
        s_cap = {s_cap[14:0], mosi};
      end else if (!s_cpha) begin
        s_idx = s_idx - 1;
        if (s_idx >= 0) miso = s_word[s_idx];
      end else begin
        if (s_idx >= 0) miso = s_word[s_idx];
        s_idx = s_idx - 1;
      end
    end
  end

  // {mode[1:0], wide, div[6:0], tx[15:0], slave[15:0]}
  localparam logic [41:0] VEC [7] = '{
    {2'd0, 1'b0, 7'd1,   16'h00A5, 16'h003C},
    {2'd1, 1'b0, 7'd2,   16'h005A, 16'h00C3},
    {2'd2, 1'b1, 7'd1,   16'hBEEF, 16'h1234},
    {2'd3, 1'b1, 7'd3,   16'h8001, 16'hF00F},
    {2'd0, 1'b1, 7'd0,   16'h7E81, 16'h55AA},
    {2'd3, 1'b0, 7'd127, 16'h0001, 16'h0080},
    {2'd2, 1'b0, 7'd0,   16'h00FF, 16'h0000}
  };

  task automatic check(input logic ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic write_reg(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1; reg_rd = 1'b0;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  // called right after the starting write; counts busy cycles, optional write injection
  task automatic poll_busy(input int inj_at, input logic [15:0] inj_d, output int dur);
    dur = 0;
    reg_addr = 3'h4; reg_rd = 1'b1;
    for (int g = 0; g < 5000; g++) begin
      if (dur == inj_at) begin
        reg_rd = 1'b0; reg_addr = 3'h0; reg_wdata = inj_d; reg_wr = 1'b1;
        dur++;
        @(negedge clk);
        reg_wr = 1'b0; reg_addr = 3'h4; reg_rd = 1'b1;
      end else begin
        #1;
        if (!reg_rdata[0]) break;
        dur++;
        @(negedge clk);
      end
    end
    reg_rd = 1'b0;
  endtask

  task automatic arm_slave(input logic [1:0] mode, input logic wide, input logic [15:0] w);
    s_cpol = mode[1]; s_cpha = mode[0]; s_word = w; s_cap = '0;
    s_idx = wide ? 15 : 7;
    if (!mode[0]) miso = w[s_idx];
    s_active = 1'b1;
  endtask

  function automatic logic [15:0] ctrl_word(input logic [1:0] mode, input logic wide,
                                            input logic [6:0] dv, input logic [1:0] ie);
    return {dv, mode[0], mode[1], ie[1], ie[0], 2'b00, wide, 1'b0, 1'b1};
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    int dur, exp_dur, nd;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    read_reg(3'h2, d); check(d == 16'h0, "R1 ctrl", d, 0);
    read_reg(3'h4, d); check(d == 16'h0, "R1 status", d, 0);
    check(sck == 1'b0, "R1 sck", sck, 0);
    check(irq == 1'b0, "R1 irq", irq, 0);

    // R2 control readback with reserved bits
    write_reg(3'h2, 16'hFFFF);
    read_reg(3'h2, d); check(d == 16'hFFE5, "R2 ctrl readback", d, 16'hFFE5);
    write_reg(3'h2, 16'h0000);

    // R8 data write while disabled
    write_reg(3'h0, 16'h00AA);
    read_reg(3'h4, d); check(d[0] == 1'b0, "R8 disabled write", d, 0);

    // vector table: R3 R4 R5 R6 R7
    foreach (VEC[i]) begin
      logic [1:0]  m;
      logic        wd;
      logic [6:0]  dv;
      logic [15:0] tx, sv, exp_rx, exp_cap;
      m = VEC[i][41:40]; wd = VEC[i][39]; dv = VEC[i][38:32];
      tx = VEC[i][31:16]; sv = VEC[i][15:0];
      nd = (dv == 0) ? 1 : int'(dv);
      exp_dur = (wd ? 16 : 8) * 2 * (nd + 1);
      exp_rx  = wd ? sv : {8'h00, sv[7:0]};
      exp_cap = wd ? tx : {8'h00, tx[7:0]};
      write_reg(3'h2, ctrl_word(m, wd, dv, 2'b00));
      repeat (2) @(negedge clk);
      check(sck == m[1], "R6 idle sck before", sck, m[1]);
      arm_slave(m, wd, sv);
      write_reg(3'h0, tx);
      poll_busy(-1, 16'h0, dur);
      s_active = 1'b0;
      check(dur == exp_dur, "R3 R4 busy length", dur, exp_dur);
      check(s_cap == exp_cap, "R5 mosi bits", s_cap, exp_cap);
      check(sck == m[1], "R6 idle sck after", sck, m[1]);
      check(mosi == tx[0], "R6 mosi hold", mosi, tx[0]);
      read_reg(3'h4, d); check(d[1] == 1'b1, "R7 rx full set", d, 2);
      read_reg(3'h0, d); check(d == exp_rx, "R5 R7 rx word", d, exp_rx);
      read_reg(3'h4, d); check(d[1] == 1'b0, "R7 rx full cleared", d, 0);
    end

    // R8 write while busy is dropped
    write_reg(3'h2, ctrl_word(2'd1, 1'b1, 7'd3, 2'b00));
    repeat (2) @(negedge clk);
    arm_slave(2'd1, 1'b1, 16'hA55A);
    write_reg(3'h0, 16'hC3A5);
    poll_busy(10, 16'h0000, dur);
    s_active = 1'b0;
    check(dur == 128, "R8 busy length unchanged", dur, 128);
    check(s_cap == 16'hC3A5, "R8 word in flight unchanged", s_cap, 16'hC3A5);
    read_reg(3'h0, d); check(d == 16'hA55A, "R8 rx word", d, 16'hA55A);

    // R10 interrupt terms
    write_reg(3'h2, ctrl_word(2'd0, 1'b0, 7'd1, 2'b10));
    @(negedge clk); check(irq == 1'b1, "R10 tx ready irq", irq, 1);
    write_reg(3'h2, 16'h0040);
    @(negedge clk); check(irq == 1'b0, "R10 gated by enable", irq, 0);
    write_reg(3'h2, ctrl_word(2'd0, 1'b0, 7'd1, 2'b01));
    @(negedge clk); check(irq == 1'b0, "R10 no rx yet", irq, 0);
    write_reg(3'h0, 16'h0000);
    @(negedge clk); check(irq == 1'b0, "R10 busy no irq", irq, 0);
    poll_busy(-1, 16'h0, dur);
    @(negedge clk); check(irq == 1'b1, "R10 rx ready irq", irq, 1);
    read_reg(3'h0, d);
    @(negedge clk); check(irq == 1'b0, "R10 irq after read", irq, 0);

    // R9 abort mid exchange
    write_reg(3'h2, ctrl_word(2'd2, 1'b1, 7'd5, 2'b00));
    repeat (2) @(negedge clk);
    write_reg(3'h0, 16'hFFFF);
    repeat (20) @(negedge clk);
    write_reg(3'h2, 16'h0080);
    @(negedge clk);
    read_reg(3'h4, d); check(d == 16'h0, "R9 busy and rx full clear", d, 0);
    check(sck == 1'b1, "R9 sck parked", sck, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule